// File: doc/BRIEF.md
# Crossing-Number Tag CAM

This block is a small content-addressable memory serving one column group of a pixel readout chip. When any pixel in the group records a hit, the current bunch-crossing number is presented on the store port. The block either finds that number already held in a slot or places it in a free slot. One cycle later it hands back the slot index. The pixel group keeps that index as a tag beside its pulse-height data, so the data can later be tied to its crossing.

A trigger presents a crossing number on the lookup port. All valid slots are compared in parallel. One cycle later the block reports a valid strobe, a hit flag and the matching slot, and a hit is what starts the transfer of that crossing's data toward the column output queue. When a crossing reaches maximum latency, its number is broadcast on the release port. Any slot holding it is invalidated and can be reused.

A full flag shows that every slot is taken. A store that needs a new slot while the block is full is dropped, flagged as an overflow and counted in a saturating counter.

The store outcome is a four-state machine whose state is the result of the previous cycle's store port:
- `SK_NONE` (code 0): no store request.
- `SK_NEW` (code 1): a slot was allocated.
- `SK_DUP` (code 2): the crossing was already held.
- `SK_DROP` (code 3): there was no room.

Every cycle the machine moves to the state picked by the current request. The transitions are:
- *idle*: no `hit_valid`, so the next state is `SK_NONE`.
- *match*: a live slot holds `hit_bx`, so the next state is `SK_DUP`.
- *allocate*: no live match and a free slot exists, so the next state is `SK_NEW`.
- *reject*: no live match and no free slot, so the next state is `SK_DROP`.

These transitions apply from any state.

Top module: `bx_tag_cam`

## Requirements
- R1: While and after reset no slot is valid: `full` is 0, `lost_count` is 0, `st_valid` and `lk_valid` are 0, and a lookup right after reset misses.
- R2: A store (`hit_valid`=1) whose crossing number no live slot holds writes it into the lowest-index free slot. One cycle later it shows `st_valid`=1, `st_kind`=1 (new) and that slot's index on `st_tag`.
- R3: A store whose crossing number a live slot already holds allocates nothing. One cycle later it shows `st_kind`=2 (duplicate) with the existing slot's index on `st_tag`. This holds even when the block is full, and then no overflow is raised.
- R4: A lookup (`lk_req`=1) gives `lk_valid`=1 one cycle later. `lk_hit` is 1 with the slot index on `lk_tag` if a valid slot holds `lk_bx`, and `lk_hit` is 0 otherwise.
- R5: A release (`rel_req`=1) invalidates any slot holding `rel_bx`. Later lookups of that number miss, and the slot becomes the first candidate for reuse when it is the lowest free index.
- R6: When a lookup and a release name the same crossing number in the same cycle, the lookup still reports the hit. The release takes effect from the next cycle on.
- R7: `full` is 1 exactly when every slot is valid, and it drops after a release frees a slot.
- R8: A store that needs a new slot while the block is full writes nothing. One cycle later it shows `st_kind`=3 (drop) and `overflow`=1, and `lost_count` rises by one, saturating at its maximum value.
- R9: A store and a release of the same crossing number in the same cycle free the old slot. The store is handled as a new allocation into the lowest slot that was free before that cycle.
- R10: At no time do two valid slots hold the same crossing number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Store request for the current crossing |
| hit_bx | input | BX_W | Crossing number to store |
| st_valid | output | 1 | Store result strobe, one cycle after the request |
| st_kind | output | 2 | Store outcome: 1 new, 2 duplicate, 3 drop |
| st_tag | output | IDX_W | Slot index returned for a new or duplicate store |
| overflow | output | 1 | Pulse: the store was dropped for lack of room |
| full | output | 1 | Every slot is valid |
| lost_count | output | LOST_W | Saturating count of dropped stores |
| lk_req | input | 1 | Lookup request |
| lk_bx | input | BX_W | Crossing number to search for |
| lk_valid | output | 1 | Lookup result strobe, one cycle after the request |
| lk_hit | output | 1 | A valid slot matched the lookup |
| lk_tag | output | IDX_W | Index of the matching slot |
| rel_req | input | 1 | Release request at maximum latency |
| rel_bx | input | BX_W | Crossing number to release |

## Verification
Store and lookup results pass through one register each, so they are due on the clock edge that follows the request. The same edge updates `full` and `lost_count`, and a release shows its effect only in requests made after that edge. The bench drives every request on a falling edge and reads the results on the next falling edge, half a cycle after the edge that produced them. Requests issued in the same cycle are therefore judged against the slot state that existed before that edge. The bench clears the request lines at that point, so each result belongs to exactly one request.

// File: rtl/bxcam_pkg.sv
package bxcam_pkg;

    // Outcome of the store port, also the state of the store result machine
    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_NEW  = 2'd1,
        SK_DUP  = 2'd2,
        SK_DROP = 2'd3
    } store_kind_e;

endpackage

// File: rtl/bxcam_first.sv
// Lowest-index-first priority encoder
module bxcam_first #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    always_comb begin
        if (found) begin
            AST_FIRST_IS_SET: assert (req[idx]);                                   // R2
            AST_FIRST_LOWEST: assert ((req & ((N'(1) << idx) - N'(1))) == '0);     // R2
        end
    end

endmodule

// File: rtl/bxcam_cmp.sv
// Parallel key compare over all slots
module bxcam_cmp #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0][W-1:0] keys,
    input  logic [W-1:0]        probe,
    output logic [N-1:0]        hits
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign hits[g] = valid[g] && (keys[g] == probe);
    end

endmodule

// File: rtl/bxcam_slots.sv
// Slot storage: valid bits and crossing-number keys
module bxcam_slots #(
    parameter int N = 8,
    parameter int W = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [W-1:0]        wr_key,
    input  logic [N-1:0]        clr,
    output logic [N-1:0]        valid,
    output logic [N-1:0][W-1:0] keys
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[g] <= 1'b0;
                keys[g]  <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                valid[g] <= 1'b1;
                keys[g]  <= wr_key;
            end else if (clr[g]) begin
                valid[g] <= 1'b0;
            end
        end
    end

    AST_WR_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !valid[wr_idx]);                                                  // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr && !wr_en) |=> ((valid & $past(clr)) == '0));                         // R5

endmodule

// File: rtl/bx_tag_cam.sv
module bx_tag_cam
    import bxcam_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int BX_W   = 8,
    parameter int LOST_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [BX_W-1:0]   hit_bx,
    output logic              st_valid,
    output logic [1:0]        st_kind,
    output logic [IDX_W-1:0]  st_tag,
    output logic              overflow,
    output logic              full,
    output logic [LOST_W-1:0] lost_count,
    input  logic              lk_req,
    input  logic [BX_W-1:0]   lk_bx,
    output logic              lk_valid,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_tag,
    input  logic              rel_req,
    input  logic [BX_W-1:0]   rel_bx
);

    logic [DEPTH-1:0]           valid;
    logic [DEPTH-1:0][BX_W-1:0] keys;
    logic [DEPTH-1:0]           st_hits, lk_hits, rel_hits, rel_clr, st_live;
    logic                       dup_found, free_found, lk_found;
    logic [IDX_W-1:0]           dup_idx, free_idx, lk_idx;
    logic                       wr_en;
    store_kind_e                st_q, st_d;
    logic [IDX_W-1:0]           tag_q;
    logic [LOST_W-1:0]          lost_q;
    logic                       lk_valid_q, lk_hit_q;
    logic [IDX_W-1:0]           lk_tag_q;

    // ---------------- compare planes ----------------
    bxcam_cmp #(.N(DEPTH), .W(BX_W)) u_cmp_st (
        .valid(valid), .keys(keys), .probe(hit_bx), .hits(st_hits));
    bxcam_cmp #(.N(DEPTH), .W(BX_W)) u_cmp_lk (
        .valid(valid), .keys(keys), .probe(lk_bx), .hits(lk_hits));
    bxcam_cmp #(.N(DEPTH), .W(BX_W)) u_cmp_rel (
        .valid(valid), .keys(keys), .probe(rel_bx), .hits(rel_hits));

    assign rel_clr = rel_req ? rel_hits : '0;
    // A slot being released this cycle no longer counts as a duplicate
    assign st_live = st_hits & ~rel_clr;

    // ---------------- encoders ----------------
    bxcam_first #(.N(DEPTH)) u_first_dup (
        .req(st_live), .found(dup_found), .idx(dup_idx));
    bxcam_first #(.N(DEPTH)) u_first_free (
        .req(~valid), .found(free_found), .idx(free_idx));
    bxcam_first #(.N(DEPTH)) u_first_lk (
        .req(lk_hits), .found(lk_found), .idx(lk_idx));

    // ---------------- slot storage ----------------
    bxcam_slots #(.N(DEPTH), .W(BX_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(free_idx), .wr_key(hit_bx),
        .clr(rel_clr), .valid(valid), .keys(keys));

    // ---------------- store result machine ----------------
    always_comb begin
        st_d  = SK_NONE;
        wr_en = 1'b0;
        if (hit_valid) begin
            if (dup_found) begin
                st_d = SK_DUP;
            end else if (free_found) begin
                st_d  = SK_NEW;
                wr_en = 1'b1;
            end else begin
                st_d = SK_DROP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SK_NONE;
            tag_q <= '0;
        end else begin
            st_q <= st_d;
            if (hit_valid) tag_q <= dup_found ? dup_idx : free_idx;
        end
    end

    always_comb begin
        st_kind = st_q;
        st_tag  = tag_q;
        unique case (st_q)
            SK_NONE: begin st_valid = 1'b0; overflow = 1'b0; end
            SK_NEW:  begin st_valid = 1'b1; overflow = 1'b0; end
            SK_DUP:  begin st_valid = 1'b1; overflow = 1'b0; end
            SK_DROP: begin st_valid = 1'b1; overflow = 1'b1; end
            default: begin st_valid = 1'b0; overflow = 1'b0; end
        endcase
    end

    // ---------------- lost-event counter ----------------
    always_ff @(posedge clk) begin
        if (!rst_n)                                lost_q <= '0;
        else if (st_d == SK_DROP && lost_q != '1)  lost_q <= lost_q + 1'b1;
    end
    assign lost_count = lost_q;
    assign full       = &valid;

    // ---------------- lookup port ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_valid_q <= 1'b0;
            lk_hit_q   <= 1'b0;
            lk_tag_q   <= '0;
        end else begin
            lk_valid_q <= lk_req;
            lk_hit_q   <= lk_req && lk_found;
            if (lk_req) lk_tag_q <= lk_idx;
        end
    end
    assign lk_valid = lk_valid_q;
    assign lk_hit   = lk_hit_q;
    assign lk_tag   = lk_tag_q;

    // ---------------- assertions ----------------
    AST_STORE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> st_valid);                                                    // R2
    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);                                                       // R4
    AST_DROP_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(full));                                                  // R8
    AST_ONE_SLOT_PER_BX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_hits));                                                         // R10
    AST_LOST_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !overflow |-> $stable(lost_count));                                         // R8

endmodule

// File: tb/bx_tag_cam_test.sv
module bx_tag_cam_test;
    import bxcam_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int BX_W   = 8;
    localparam int LOST_W = 8;
    localparam int IDX_W  = 3;

    localparam logic [1:0] OP_ST = 2'd0;
    localparam logic [1:0] OP_LK = 2'd1;
    localparam logic [1:0] OP_RL = 2'd2;
    localparam int NVEC = 11;
    // {op, bx, result (kind or hit), tag}
    localparam logic [14:0] VEC [NVEC] = '{
        {OP_ST, 8'd10, 2'd1, 3'd0},   // R2 new
        {OP_ST, 8'd20, 2'd1, 3'd1},   // R2 new
        {OP_ST, 8'd10, 2'd2, 3'd0},   // R3 duplicate
        {OP_LK, 8'd20, 2'd1, 3'd1},   // R4 hit
        {OP_LK, 8'd30, 2'd0, 3'd0},   // R4 miss
        {OP_RL, 8'd10, 2'd0, 3'd0},   // R5 release
        {OP_LK, 8'd10, 2'd0, 3'd0},   // R5 miss after release
        {OP_ST, 8'd30, 2'd1, 3'd0},   // R5 reuse lowest slot
        {OP_LK, 8'd30, 2'd1, 3'd0},   // R4 hit
        {OP_RL, 8'd20, 2'd0, 3'd0},   // R5 release
        {OP_ST, 8'd40, 2'd1, 3'd1}    // R5 reuse
    };

    logic clk = 1'b0;
    logic rst_n;
    logic hit_valid, lk_req, rel_req;
    logic [BX_W-1:0] hit_bx, lk_bx, rel_bx;
    logic st_valid, overflow, full, lk_valid, lk_hit;
    logic [1:0] st_kind;
    logic [IDX_W-1:0] st_tag, lk_tag;
    logic [LOST_W-1:0] lost_count;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    bx_tag_cam #(.DEPTH(DEPTH), .BX_W(BX_W), .LOST_W(LOST_W)) uut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        hit_valid = 1'b0;
        lk_req    = 1'b0;
        rel_req   = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic do_store(input logic [BX_W-1:0] bx);
        hit_valid = 1'b1; hit_bx = bx;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_lookup(input logic [BX_W-1:0] bx);
        lk_req = 1'b1; lk_bx = bx;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle_inputs();
        hit_bx = '0; lk_bx = '0; rel_bx = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "full in reset", int'(full), 0);
        chk("R1", "lost in reset", int'(lost_count), 0);
        chk("R1", "st_valid in reset", int'(st_valid), 0);
        chk("R1", "lk_valid in reset", int'(lk_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_lookup(8'd10);
        chk("R1", "lookup after reset valid", int'(lk_valid), 1);
        chk("R1", "lookup after reset hit", int'(lk_hit), 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] op;
            logic [7:0] bx;
            logic [1:0] res;
            logic [2:0] tg;
            {op, bx, res, tg} = VEC[v];
            case (op)
                OP_ST: begin
                    do_store(bx);
                    chk(res == 2'd1 ? "R2" : "R3", "store valid", int'(st_valid), 1);
                    chk(res == 2'd1 ? "R2" : "R3", "store kind", int'(st_kind), int'(res));
                    chk(res == 2'd1 ? "R2" : "R3", "store tag", int'(st_tag), int'(tg));
                end
                OP_LK: begin
                    do_lookup(bx);
                    chk("R4", "lookup valid", int'(lk_valid), 1);
                    chk("R4", "lookup hit", int'(lk_hit), int'(res[0]));
                    if (res[0]) chk("R4", "lookup tag", int'(lk_tag), int'(tg));
                end
                default: begin
                    rel_req = 1'b1; rel_bx = bx;
                    @(negedge clk);
                    idle_inputs();
                    chk("R5", "no strobe on release", int'(st_valid | lk_valid), 0);
                end
            endcase
        end

        // fill remaining slots 2..7
        for (int k = 0; k < 6; k++) begin
            do_store(8'(100 + k));
            chk("R2", "fill tag", int'(st_tag), k + 2);
            chk("R7", "full while filling", int'(full), (k == 5) ? 1 : 0);
        end

        do_store(8'd106);
        chk("R8", "drop kind", int'(st_kind), 3);
        chk("R8", "overflow pulse", int'(overflow), 1);
        chk("R8", "lost count", int'(lost_count), 1);
        chk("R7", "still full", int'(full), 1);

        do_store(8'd30);
        chk("R3", "dup when full kind", int'(st_kind), 2);
        chk("R3", "dup when full tag", int'(st_tag), 0);
        chk("R3", "no overflow on dup", int'(overflow), 0);
        chk("R3", "lost unchanged", int'(lost_count), 1);

        // lookup and release of the same crossing together
        lk_req = 1'b1; lk_bx = 8'd40; rel_req = 1'b1; rel_bx = 8'd40;
        @(negedge clk);
        idle_inputs();
        chk("R6", "lookup sees old entry", int'(lk_hit), 1);
        chk("R6", "lookup old tag", int'(lk_tag), 1);
        chk("R7", "full drops after release", int'(full), 0);
        do_lookup(8'd40);
        chk("R6", "release effective next cycle", int'(lk_hit), 0);

        // store and release of the same crossing together
        hit_valid = 1'b1; hit_bx = 8'd30; rel_req = 1'b1; rel_bx = 8'd30;
        @(negedge clk);
        idle_inputs();
        chk("R9", "store kind new", int'(st_kind), 1);
        chk("R9", "store into prior free slot", int'(st_tag), 1);
        do_lookup(8'd30);
        chk("R9", "lookup hit", int'(lk_hit), 1);
        chk("R9", "lookup moved tag", int'(lk_tag), 1);
        chk("R10", "full clear with slot 0 freed", int'(full), 0);

        do_store(8'd50);
        chk("R2", "lowest free reused", int'(st_tag), 0);
        chk("R7", "full again", int'(full), 1);

        // saturation of the lost counter
        for (int k = 0; k < 260; k++) do_store(8'd150);
        chk("R8", "lost saturates", int'(lost_count), 255);
        chk("R8", "overflow still flagged", int'(overflow), 1);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule